// File: doc/BRIEF.md
# Two-Phase Page Transfer Engine

This block moves one fixed-size page of 512 bytes between host memory and a NAND card, passing through an on-board page buffer. Each transfer takes two phases, and software starts each one with its own write to a command register. The memory phase moves the page between host memory and the buffer over a byte-wide bus-master request/acknowledge port. The internal phase moves it between the buffer and the card over a byte-wide card port.

Direction decides which phase comes first. When data comes from the card, the internal phase fills the buffer and the memory phase then empties it to host memory. When data goes to the card, the memory phase loads the buffer from host memory and the internal phase then drains it to the card. Each phase sets its own completion flag in an interrupt status register. A commanding error sets a separate flag, and so does an error response from memory. The interrupt line is the OR of the status flags that are enabled.

A read-only capability word tells software whether transfers are usable. Software sees a transfer as usable only when bits 6 and 7 of that word are both set.

Top module: `dma2_page_engine`

## Requirements
- R1: After reset, the address, command, status and enable registers read 0, the capability word reads 0xC0, `irq` is low, and neither `mem_req` nor `card_req` is asserted.
- R2: Register word offsets are 0 for the host base address (32 bits), 1 for command, 2 for status, 3 for enable and 4 for capability. Command bit 0 starts the memory phase, bit 1 selects the direction (1 = card toward host, 0 = host toward card) and bit 2 starts the internal phase. Status and enable share one layout: bit 0 is memory phase done, bit 1 is error and bit 2 is internal phase done. Unused bits read 0.
- R3: With direction 1, the internal phase reads 512 bytes from the card in order into the buffer. The following memory phase writes them to host addresses base through base+511 in the same order.
- R4: With direction 0, the memory phase reads host addresses base through base+511 into the buffer. The following internal phase writes those bytes to the card in the same order.
- R5: One byte moves on every clock edge where the active port's request and acknowledge are both high. The request stays asserted with a stable address until it is acknowledged. The phase-done status bit is set at the same edge that moves the last byte, and at that edge the request drops.
- R6: Writing 1 to a status bit clears it. Writing 0 to a status bit leaves it unchanged.
- R7: `irq` is high exactly when some status bit and its enable bit are both set. An enable value of 0 masks every source.
- R8: A command write with both bit 0 and bit 2 set sets the error bit, starts no phase and leaves the command register unchanged.
- R9: A nonzero command write while a phase runs sets the error bit and leaves the running phase untouched.
- R10: Writing 0 to the command register stops any running phase at once, returns the engine to idle and sets no done bit.
- R11: An error response from memory (`mem_err` together with `mem_ack`) ends the memory phase at that edge and sets the error bit instead of the done bit.
- R12: A request on either port is raised only in the cycle after a command-register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Host memory request |
| mem_we | output | 1 | Host memory write (1) or read (0) |
| mem_addr | output | 32 | Host memory byte address |
| mem_wdata | output | 8 | Byte written to host memory |
| mem_ack | input | 1 | Host memory acknowledge |
| mem_err | input | 1 | Error response, valid with mem_ack |
| mem_rdata | input | 8 | Byte read from host memory |
| card_req | output | 1 | Card byte request |
| card_we | output | 1 | Card write (1) or read (0) |
| card_wdata | output | 8 | Byte written to card |
| card_ack | input | 1 | Card acknowledge |
| card_rdata | input | 8 | Byte read from card |

## Verification
Full round trips go from host to card and back from card to host. They run with different base addresses and different data seeds, so a wrong address step, a swapped direction or a byte-order slip shows up as a data mismatch. Each round trip runs once with acknowledges on every cycle, where the per-phase cycle count must be exactly 512 and so exposes off-by-one completion. It runs again with acknowledges on alternate cycles, which separates "one byte per acknowledged edge" from "one byte per cycle". Directed cases cover the following:
- a command with both phase bits set
- a command written while a phase runs
- a stop written in the middle of a phase
- a memory error response partway through a page
- the interrupt masking and write-one-to-clear behaviour

Each directed case checks that the right status bit appears and that the ports go quiet.

// File: rtl/dma2_pkg.sv
package dma2_pkg;
    localparam int DATA_W = 32;
    localparam int OFF_W  = 3;

    localparam logic [OFF_W-1:0] OFF_ADDR = 3'd0;
    localparam logic [OFF_W-1:0] OFF_CMD  = 3'd1;
    localparam logic [OFF_W-1:0] OFF_STS  = 3'd2;
    localparam logic [OFF_W-1:0] OFF_EN   = 3'd3;
    localparam logic [OFF_W-1:0] OFF_CAP  = 3'd4;

    // command bit positions
    localparam int CB_MEM = 0;
    localparam int CB_DIR = 1;
    localparam int CB_INT = 2;

    // status / enable bit positions
    localparam int IB_MEM = 0;
    localparam int IB_ERR = 1;
    localparam int IB_INT = 2;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_MEM  = 2'd1,
        PH_INT  = 2'd2
    } phase_e;
endpackage

// File: rtl/dma2_pagebuf.sv
module dma2_pagebuf #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = mem_q[addr];
endmodule

// File: rtl/dma2_phase_ctrl.sv
module dma2_phase_ctrl
    import dma2_pkg::*;
#(
    parameter int PAGE   = 512,
    parameter int ADDR_W = 32,
    localparam int CW    = $clog2(PAGE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_mem,
    input  logic              start_int,
    input  logic              dir_in,
    input  logic              stop,
    input  logic [ADDR_W-1:0] base_in,
    output logic              busy,
    output logic              ev_mem_done,
    output logic              ev_int_done,
    output logic              ev_mem_err,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [7:0]        mem_rdata,
    output logic              card_req,
    output logic              card_we,
    output logic [7:0]        card_wdata,
    input  logic              card_ack,
    input  logic [7:0]        card_rdata,
    output logic              buf_we,
    output logic [CW-1:0]     buf_addr,
    output logic [7:0]        buf_wdata,
    input  logic [7:0]        buf_rdata
);
    localparam logic [CW-1:0] LAST = CW'(PAGE - 1);

    typedef struct packed {
        phase_e            ph;
        logic              dir;
        logic [CW-1:0]     cnt;
        logic [ADDR_W-1:0] base;
    } ctl_t;

    ctl_t q, d;

    always_comb begin
        d           = q;
        ev_mem_done = 1'b0;
        ev_int_done = 1'b0;
        ev_mem_err  = 1'b0;
        buf_we      = 1'b0;
        if (stop) begin
            d.ph  = PH_IDLE;
            d.cnt = '0;
        end else begin
            case (q.ph)
                PH_IDLE: begin
                    if (start_mem || start_int) begin
                        d.ph   = start_mem ? PH_MEM : PH_INT;
                        d.dir  = dir_in;
                        d.cnt  = '0;
                        d.base = base_in;
                    end
                end
                PH_MEM: begin
                    if (mem_ack) begin
                        if (mem_err) begin
                            ev_mem_err = 1'b1;
                            d.ph       = PH_IDLE;
                            d.cnt      = '0;
                        end else begin
                            buf_we = !q.dir;
                            if (q.cnt == LAST) begin
                                ev_mem_done = 1'b1;
                                d.ph        = PH_IDLE;
                                d.cnt       = '0;
                            end else begin
                                d.cnt = q.cnt + 1'b1;
                            end
                        end
                    end
                end
                PH_INT: begin
                    if (card_ack) begin
                        buf_we = q.dir;
                        if (q.cnt == LAST) begin
                            ev_int_done = 1'b1;
                            d.ph        = PH_IDLE;
                            d.cnt       = '0;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                default: d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{ph: PH_IDLE, dir: 1'b0, cnt: '0, base: '0};
        end else begin
            q <= d;
        end
    end

    assign busy       = (q.ph != PH_IDLE);
    assign mem_req    = (q.ph == PH_MEM);
    assign mem_we     = q.dir;
    assign mem_addr   = q.base + {{(ADDR_W-CW){1'b0}}, q.cnt};
    assign mem_wdata  = buf_rdata;
    assign card_req   = (q.ph == PH_INT);
    assign card_we    = !q.dir;
    assign card_wdata = buf_rdata;
    assign buf_addr   = q.cnt;
    assign buf_wdata  = (q.ph == PH_MEM) ? mem_rdata : card_rdata;
endmodule

// File: rtl/dma2_regs.sv
module dma2_regs
    import dma2_pkg::*;
#(
    parameter int   ADDR_W  = 32,
    parameter logic DMA_OK  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [OFF_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    input  logic              busy,
    input  logic              ev_mem_done,
    input  logic              ev_int_done,
    input  logic              ev_mem_err,
    output logic              start_mem,
    output logic              start_int,
    output logic              dir_out,
    output logic              stop,
    output logic [ADDR_W-1:0] base_out
);
    localparam logic [7:0] CAP_WORD = {DMA_OK, DMA_OK, 6'b0};

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [2:0]        cmd;
        logic [2:0]        sts;
        logic [2:0]        en;
    } regs_t;

    regs_t q, d;
    logic  cmd_err;
    logic [2:0] wv;

    always_comb begin
        d         = q;
        start_mem = 1'b0;
        start_int = 1'b0;
        stop      = 1'b0;
        cmd_err   = 1'b0;
        wv        = reg_wdata[2:0];
        if (reg_wr) begin
            case (reg_addr)
                OFF_ADDR: d.addr = reg_wdata[ADDR_W-1:0];
                OFF_CMD: begin
                    if (wv == 3'b000) begin
                        stop  = 1'b1;
                        d.cmd = 3'b000;
                    end else if (busy || (wv[CB_MEM] && wv[CB_INT])) begin
                        cmd_err = 1'b1;
                    end else begin
                        d.cmd     = wv;
                        start_mem = wv[CB_MEM];
                        start_int = wv[CB_INT];
                    end
                end
                OFF_STS: d.sts = q.sts & ~wv;
                OFF_EN:  d.en  = wv;
                default: ;
            endcase
        end
        d.sts[IB_MEM] = d.sts[IB_MEM] | ev_mem_done;
        d.sts[IB_INT] = d.sts[IB_INT] | ev_int_done;
        d.sts[IB_ERR] = d.sts[IB_ERR] | ev_mem_err | cmd_err;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (reg_addr)
            OFF_ADDR: reg_rdata = DATA_W'(q.addr);
            OFF_CMD:  reg_rdata = DATA_W'(q.cmd);
            OFF_STS:  reg_rdata = DATA_W'(q.sts);
            OFF_EN:   reg_rdata = DATA_W'(q.en);
            OFF_CAP:  reg_rdata = DATA_W'(CAP_WORD);
            default:  reg_rdata = '0;
        endcase
    end

    assign irq      = |(q.sts & q.en);
    assign dir_out  = reg_wdata[CB_DIR];
    assign base_out = q.addr;
endmodule

// File: rtl/dma2_page_engine.sv
module dma2_page_engine
    import dma2_pkg::*;
#(
    parameter int   PAGE   = 512,
    parameter int   ADDR_W = 32,
    parameter logic DMA_OK = 1'b1,
    localparam int  CW     = $clog2(PAGE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [7:0]        mem_rdata,
    output logic              card_req,
    output logic              card_we,
    output logic [7:0]        card_wdata,
    input  logic              card_ack,
    input  logic [7:0]        card_rdata
);
    logic              busy, ev_mem_done, ev_int_done, ev_mem_err;
    logic              start_mem, start_int, dir_sel, stop;
    logic [ADDR_W-1:0] base;
    logic              buf_we;
    logic [CW-1:0]     buf_addr;
    logic [7:0]        buf_wdata, buf_rdata;

    dma2_regs #(.ADDR_W(ADDR_W), .DMA_OK(DMA_OK)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .irq         (irq),
        .busy        (busy),
        .ev_mem_done (ev_mem_done),
        .ev_int_done (ev_int_done),
        .ev_mem_err  (ev_mem_err),
        .start_mem   (start_mem),
        .start_int   (start_int),
        .dir_out     (dir_sel),
        .stop        (stop),
        .base_out    (base)
    );

    dma2_phase_ctrl #(.PAGE(PAGE), .ADDR_W(ADDR_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_mem   (start_mem),
        .start_int   (start_int),
        .dir_in      (dir_sel),
        .stop        (stop),
        .base_in     (base),
        .busy        (busy),
        .ev_mem_done (ev_mem_done),
        .ev_int_done (ev_int_done),
        .ev_mem_err  (ev_mem_err),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_ack     (mem_ack),
        .mem_err     (mem_err),
        .mem_rdata   (mem_rdata),
        .card_req    (card_req),
        .card_we     (card_we),
        .card_wdata  (card_wdata),
        .card_ack    (card_ack),
        .card_rdata  (card_rdata),
        .buf_we      (buf_we),
        .buf_addr    (buf_addr),
        .buf_wdata   (buf_wdata),
        .buf_rdata   (buf_rdata)
    );

    dma2_pagebuf #(.DEPTH(PAGE), .WIDTH(8)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .addr  (buf_addr),
        .wdata (buf_wdata),
        .rdata (buf_rdata)
    );
endmodule

// File: rtl/dma2_page_engine_chk.sv
module dma2_page_engine_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic              mem_err,
    input logic              card_req,
    input logic              card_ack
);
    // R5: the two ports never run together
    p_sides_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && card_req));

    // R5: an unacknowledged memory request holds with a stable address
    p_mem_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !reg_wr) |=> (mem_req && $stable(mem_addr)));

    // R5: an unacknowledged card request holds
    p_card_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (card_req && !card_ack && !reg_wr) |=> card_req);

    // R3: each accepted byte advances the host address by one
    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !mem_err && !reg_wr) |=>
            (!mem_req || (mem_addr == $past(mem_addr) + 1'b1)));

    // R11: an error response ends the memory phase
    p_err_ends_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_err) |=> !mem_req);

    // R12: requests only start after a command write
    p_start_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_req) || $rose(card_req)) |-> $past(reg_wr));
endmodule

bind dma2_page_engine dma2_page_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack),
    .mem_err  (mem_err),
    .card_req (card_req),
    .card_ack (card_ack)
);

// File: tb/tb_dma2_page_engine.sv
`timescale 1ns/1ps
module tb_dma2_page_engine;
    localparam int PAGE = 512;
    localparam int NV   = 4;
    localparam logic [31:0] V_BASE  [NV] = '{32'h0000_0000, 32'h1000_00A5, 32'h8000_01FF, 32'h0000_0200};
    localparam logic [7:0]  V_SEED  [NV] = '{8'h11, 8'h5A, 8'hC3, 8'h00};
    localparam logic        V_STALL [NV] = '{1'b0, 1'b1, 1'b0, 1'b1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        mem_req, mem_we, mem_ack, mem_err;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        card_req, card_we, card_ack;
    logic [7:0]  card_wdata, card_rdata;

    logic [7:0]  hostmem  [2048];
    logic [7:0]  card_src [PAGE];
    logic [7:0]  card_dst [PAGE];
    int          card_idx = 0;
    logic [15:0] cyc = 16'd0;
    logic        stall = 1'b0;
    logic        hold_mem = 1'b0;
    logic        err_arm = 1'b0;
    logic [10:0] err_at = 11'd0;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    dma2_page_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
        .mem_rdata(mem_rdata), .card_req(card_req), .card_we(card_we),
        .card_wdata(card_wdata), .card_ack(card_ack), .card_rdata(card_rdata)
    );

    assign mem_ack    = mem_req && !hold_mem && (!stall || cyc[0]);
    assign card_ack   = card_req && (!stall || cyc[0]);
    assign mem_rdata  = hostmem[mem_addr[10:0]];
    assign mem_err    = err_arm && (mem_addr[10:0] == err_at);
    assign card_rdata = card_src[card_idx[8:0]];

    // memory and card models, updated on the same edge the design samples
    always @(posedge clk) begin
        cyc <= cyc + 16'd1;
        if (mem_req && mem_ack && mem_we && !mem_err)
            hostmem[mem_addr[10:0]] <= mem_wdata;
        if (card_req && card_ack) begin
            if (card_we) card_dst[card_idx[8:0]] <= card_wdata;
            card_idx <= card_idx + 1;
        end else if (!card_req) begin
            card_idx <= 0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    // counts negedges with a request high, starting at the current negedge
    task automatic wait_idle(output int n);
        n = 0;
        while ((mem_req || card_req) && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    function automatic logic [7:0] pat_w(input logic [7:0] s, input int i);
        return s + 8'(i * 3);
    endfunction

    function automatic logic [7:0] pat_r(input logic [7:0] s, input int i);
        return 8'(int'(s) * 5 + i * 11 + 1);
    endfunction

    initial begin
        #600000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int n, bad;
        logic [31:0] base, base2;
        for (int i = 0; i < 2048; i++) hostmem[i] = 8'h00;
        for (int i = 0; i < PAGE; i++) begin card_src[i] = 8'h00; card_dst[i] = 8'h00; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, r); check("R1 addr", r, 32'h0);
        rd(3'd1, r); check("R1 cmd", r, 32'h0);
        rd(3'd2, r); check("R1 status", r, 32'h0);
        rd(3'd3, r); check("R1 enable", r, 32'h0);
        rd(3'd4, r); check("R1 capability", r, 32'hC0);
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 reqs", {30'd0, mem_req, card_req}, 32'd0);

        // vector table: host->card then card->host round trips
        for (int v = 0; v < NV; v++) begin
            base  = V_BASE[v];
            base2 = base ^ 32'h0000_0400;
            stall = V_STALL[v];
            for (int i = 0; i < PAGE; i++) begin
                hostmem[(base[10:0] + 11'(i))] = pat_w(V_SEED[v], i);
                card_src[i] = pat_r(V_SEED[v], i);
            end
            // R4 memory phase, direction 0
            wr(3'd0, base);
            wr(3'd2, 32'h7);
            wr(3'd1, 32'h1);
            wait_idle(n);
            if (!V_STALL[v]) check("R5 memory phase cycles", n, PAGE);
            rd(3'd2, r); check("R5 mem done only", r, 32'h1);
            // R4 internal phase, direction 0
            wr(3'd2, 32'h7);
            wr(3'd1, 32'h4);
            wait_idle(n);
            if (!V_STALL[v]) check("R5 internal phase cycles", n, PAGE);
            rd(3'd2, r); check("R4 int done only", r, 32'h4);
            bad = 0;
            for (int i = 0; i < PAGE; i++) if (card_dst[i] !== pat_w(V_SEED[v], i)) bad++;
            check("R4 card bytes mismatched", bad, 0);
            // R3 internal phase, direction 1
            wr(3'd2, 32'h7);
            wr(3'd1, 32'h6);
            wait_idle(n);
            rd(3'd2, r); check("R3 int done only", r, 32'h4);
            // R3 memory phase, direction 1
            wr(3'd0, base2);
            wr(3'd2, 32'h7);
            wr(3'd1, 32'h3);
            wait_idle(n);
            rd(3'd2, r); check("R3 mem done only", r, 32'h1);
            bad = 0;
            for (int i = 0; i < PAGE; i++)
                if (hostmem[(base2[10:0] + 11'(i))] !== pat_r(V_SEED[v], i)) bad++;
            check("R3 host bytes mismatched", bad, 0);
        end
        stall = 1'b0;
        wr(3'd2, 32'h7);

        // R2 unused enable bits read zero
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd3, r); check("R2 enable width", r, 32'h7);
        wr(3'd3, 32'h0);

        // R8 both phase bits
        wr(3'd1, 32'h5);
        rd(3'd2, r); check("R8 error bit", r, 32'h2);
        check("R8 no request", {30'd0, mem_req, card_req}, 32'd0);
        rd(3'd1, r); check("R8 cmd unchanged", r, 32'h3);

        // R7 masking and R6 write-one-to-clear
        check("R7 masked irq", {31'd0, irq}, 32'd0);
        wr(3'd3, 32'h1);
        check("R7 other bit enabled", {31'd0, irq}, 32'd0);
        wr(3'd3, 32'h2);
        check("R7 irq asserted", {31'd0, irq}, 32'd1);
        wr(3'd2, 32'h1);
        rd(3'd2, r); check("R6 other bit kept", r, 32'h2);
        wr(3'd2, 32'h2);
        rd(3'd2, r); check("R6 cleared", r, 32'h0);
        check("R7 irq after clear", {31'd0, irq}, 32'd0);
        wr(3'd3, 32'h0);

        // R9 write while busy, then R10 stop
        hold_mem = 1'b1;
        wr(3'd0, 32'h0000_0100);
        wr(3'd1, 32'h1);
        check("R9 phase running", {31'd0, mem_req}, 32'd1);
        wr(3'd1, 32'h4);
        rd(3'd2, r); check("R9 error bit", r, 32'h2);
        check("R9 phase untouched", {30'd0, mem_req, card_req}, 32'h2);
        rd(3'd1, r); check("R9 cmd unchanged", r, 32'h1);
        wr(3'd1, 32'h0);
        check("R10 stopped", {30'd0, mem_req, card_req}, 32'd0);
        hold_mem = 1'b0;
        repeat (5) @(negedge clk);
        check("R10 stays idle", {30'd0, mem_req, card_req}, 32'd0);
        rd(3'd2, r); check("R10 no done bit", r, 32'h2);
        wr(3'd2, 32'h7);

        // R11 memory error response on the eleventh byte
        err_at = 11'h300 + 11'd10;
        err_arm = 1'b1;
        wr(3'd0, 32'h0000_0300);
        wr(3'd1, 32'h1);
        wait_idle(n);
        err_arm = 1'b0;
        check("R11 bytes before error", n, 11);
        rd(3'd2, r); check("R11 error not done", r, 32'h2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule